// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block puts a command interpreter behind a parallel, strobe-driven flash-style bus. The bus has active-low chip select, write strobe and read strobe, an address and an 8-bit data path. All bus inputs are taken as synchronous to `clk`. Host writes are grouped into keyed command sequences that program one byte, erase the whole array, or erase one or more sectors. A small register array stands in for the cells.

Once a sequence completes, the block runs an embedded operation whose length is a fixed, parameterised number of clock cycles. While it runs, reads return a status byte instead of array data, and every write is ignored. When the operation finishes, the block returns to array read mode. Programming can only clear bits. Only an erase brings bits back to 1.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array read mode, every array byte reads FFh, and the first status bit 6 seen is 0.
- R2: A read is a cycle with chip select and read strobe low and write strobe high. It returns the array byte at the low `MEM_AW` address bits. In any cycle without a read, `dout` is 00h.
- R3: A write's address is taken in the first cycle in which chip select and write strobe are both low. Its data is taken from the last such cycle. The write is acted on in the cycle after either strobe goes high.
- R4: The write sequence AAh@555h, 55h@2AAh, A0h@555h, then data D at address A, starts a program operation. It lasts `PGM_CYC` cycles, after which the block is back in read mode and A reads the new value.
- R5: Programming stores (old AND D): a 0 bit is never turned back to 1 by a program.
- R6: During a program, a read returns a status byte. Bit 7 is the inverse of D bit 7, bit 6 flips after every status read, and bits 5..0 are 0.
- R7: While an embedded program or erase runs, every write is ignored, including complete command sequences.
- R8: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h starts a chip erase. It lasts `ERS_CYC` cycles and leaves every byte at FFh. Status bit 7 reads 0 while it runs.
- R9: If the sixth write of the erase sequence is instead 30h to any address, it opens a sector window of `SE_WIN` idle cycles. The sector is address bits [MEM_AW-1 : MEM_AW-SECT_AW]. Each 30h write within the window adds its sector, and any active write restarts the window. When the window expires, all chosen sectors become FFh after `ERS_CYC` cycles, and the other sectors are unchanged.
- R10: Any write other than 30h during the sector window closes it. The block returns to read mode and nothing is erased.
- R11: A write that does not match the next expected step of a sequence returns the block to read mode without touching the array. F0h is one such write. The data write of a program sequence is exempt from this rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | AW | Byte address (command keys use bits 10..0) |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status, 00h when not reading |

## Verification
The bench builds the block with a 64-byte array in four 16-byte sectors. It sets a 40-cycle program, a 60-cycle erase and a 24-cycle sector window. These short counts let it do several things in a single run: write a complete second program sequence inside one busy period, open a sector window and add a second sector, and let a window expire and then hit the busy erase with a late 30h write. It also reads all 64 bytes back after a chip erase.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_SET,
        ST_ERS_SET,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_SECT_WIN,
        ST_PGM_BUSY,
        ST_ERS_BUSY
    } seq_state_e;

    localparam int          KEY_AW       = 11;
    localparam logic [10:0] KEY_ADDR_A   = 11'h555;
    localparam logic [10:0] KEY_ADDR_B   = 11'h2AA;
    localparam logic [7:0]  KEY_DATA_A   = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B   = 8'h55;
    localparam logic [7:0]  OP_PROGRAM   = 8'hA0;
    localparam logic [7:0]  OP_ERASE_PRE = 8'h80;
    localparam logic [7:0]  OP_CHIP      = 8'h10;
    localparam logic [7:0]  OP_SECTOR    = 8'h30;

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_active,
    output logic          rd_active,
    output logic          wr_done,
    output logic          rd_end,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] a;
        logic [7:0]    d;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        wr_active = ~ce_n & ~we_n;
        rd_active = ~ce_n & ~oe_n & we_n;
        cap_d     = cap_q;
        cap_d.wr  = wr_active;
        cap_d.rd  = rd_active;
        // address frozen when both strobes first meet low
        if (wr_active && !cap_q.wr) cap_d.a = addr;
        // data keeps following the bus until a strobe rises
        if (wr_active) cap_d.d = din;
        wr_done = cap_q.wr & ~wr_active;
        rd_end  = cap_q.rd & ~rd_active;
        wr_addr = cap_q.a;
        wr_data = cap_q.d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int AW      = 11,
    parameter int MEM_AW  = 8,
    parameter int SECT_AW = 2,
    parameter int PGM_CYC = 400,
    parameter int ERS_CYC = 2000,
    parameter int SE_WIN  = 500
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_active,
    input  logic                     wr_done,
    input  logic                     rd_end,
    input  logic [AW-1:0]            wr_addr,
    input  logic [7:0]               wr_data,
    output seq_state_e               state,
    output logic                     show_status,
    output logic [7:0]               status,
    output logic                     prog_go,
    output logic [MEM_AW-1:0]        prog_addr,
    output logic [7:0]               prog_data,
    output logic                     erase_go,
    output logic [(1<<SECT_AW)-1:0]  erase_mask
);
    localparam int NSECT = 1 << SECT_AW;
    localparam int MAXAB = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
    localparam int MAXC  = (MAXAB > SE_WIN) ? MAXAB : SE_WIN;
    localparam int CW    = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CW-1:0]     cnt;
        logic [MEM_AW-1:0] tgt_addr;
        logic [7:0]        tgt_data;
        logic [NSECT-1:0]  mask;
        logic              tog;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  key_a, key_b;
    logic [SECT_AW-1:0] sect;

    always_comb begin
        key_a    = (wr_addr[KEY_AW-1:0] == KEY_ADDR_A);
        key_b    = (wr_addr[KEY_AW-1:0] == KEY_ADDR_B);
        sect     = wr_addr[MEM_AW-1 -: SECT_AW];
        c_d      = c_q;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        show_status = (c_q.state == ST_PGM_BUSY) || (c_q.state == ST_ERS_BUSY)
                   || (c_q.state == ST_SECT_WIN);

        case (c_q.state)
            ST_PGM_BUSY: begin
                if (c_q.cnt == CW'(1)) begin
                    prog_go      = 1'b1;
                    c_d.state    = ST_READ;
                    c_d.tgt_addr = '0;
                end else begin
                    c_d.cnt = c_q.cnt - CW'(1);
                end
            end
            ST_ERS_BUSY: begin
                if (c_q.cnt == CW'(1)) begin
                    erase_go  = 1'b1;
                    c_d.state = ST_READ;
                    c_d.mask  = '0;
                end else begin
                    c_d.cnt = c_q.cnt - CW'(1);
                end
            end
            ST_SECT_WIN: begin
                if (wr_done) begin
                    if (wr_data == OP_SECTOR) begin
                        c_d.mask = c_q.mask | (NSECT'(1) << sect);
                        c_d.cnt  = CW'(SE_WIN);
                    end else begin
                        c_d.state = ST_READ;
                        c_d.mask  = '0;
                    end
                end else if (wr_active) begin
                    c_d.cnt = CW'(SE_WIN);
                end else if (c_q.cnt == CW'(1)) begin
                    c_d.state = ST_ERS_BUSY;
                    c_d.cnt   = CW'(ERS_CYC);
                end else begin
                    c_d.cnt = c_q.cnt - CW'(1);
                end
            end
            default: begin
                if (wr_done) begin
                    c_d.state = ST_READ;
                    case (c_q.state)
                        ST_READ:
                            if (key_a && wr_data == KEY_DATA_A) c_d.state = ST_UNL1;
                        ST_UNL1:
                            if (key_b && wr_data == KEY_DATA_B) c_d.state = ST_UNL2;
                        ST_UNL2: begin
                            if (key_a && wr_data == OP_PROGRAM)   c_d.state = ST_PGM_SET;
                            if (key_a && wr_data == OP_ERASE_PRE) c_d.state = ST_ERS_SET;
                        end
                        ST_PGM_SET: begin
                            c_d.state    = ST_PGM_BUSY;
                            c_d.cnt      = CW'(PGM_CYC);
                            c_d.tgt_addr = wr_addr[MEM_AW-1:0];
                            c_d.tgt_data = wr_data;
                        end
                        ST_ERS_SET:
                            if (key_a && wr_data == KEY_DATA_A) c_d.state = ST_ERS_UNL1;
                        ST_ERS_UNL1:
                            if (key_b && wr_data == KEY_DATA_B) c_d.state = ST_ERS_UNL2;
                        ST_ERS_UNL2: begin
                            if (key_a && wr_data == OP_CHIP) begin
                                c_d.state = ST_ERS_BUSY;
                                c_d.cnt   = CW'(ERS_CYC);
                                c_d.mask  = '1;
                            end else if (wr_data == OP_SECTOR) begin
                                c_d.state = ST_SECT_WIN;
                                c_d.cnt   = CW'(SE_WIN);
                                c_d.mask  = NSECT'(1) << sect;
                            end
                        end
                        default: c_d.state = ST_READ;
                    endcase
                end
            end
        endcase

        if (rd_end && show_status) c_d.tog = ~c_q.tog;

        state      = c_q.state;
        status     = {(c_q.state == ST_PGM_BUSY) ? ~c_q.tgt_data[7] : 1'b0, c_q.tog, 6'b0};
        prog_addr  = c_q.tgt_addr;
        prog_data  = c_q.tgt_data;
        erase_mask = c_q.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_READ;
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int MEM_AW  = 8,
    parameter int SECT_AW = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prog_go,
    input  logic [MEM_AW-1:0]       prog_addr,
    input  logic [7:0]              prog_data,
    input  logic                    erase_go,
    input  logic [(1<<SECT_AW)-1:0] erase_mask,
    input  logic [MEM_AW-1:0]       raddr,
    output logic [7:0]              rdata
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam int SBITS = MEM_AW - SECT_AW;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (erase_go && erase_mask[i >> SBITS]) mem_d[i] = 8'hFF;
        end
        // a program can only pull bits low
        if (prog_go) mem_d[prog_addr] = mem_q[prog_addr] & prog_data;
        rdata = mem_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int AW      = 11,
    parameter int MEM_AW  = 8,
    parameter int SECT_AW = 2,
    parameter int PGM_CYC = 400,
    parameter int ERS_CYC = 2000,
    parameter int SE_WIN  = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dout
);
    localparam int NSECT = 1 << SECT_AW;

    logic              wr_active, rd_active, wr_done, rd_end;
    logic [AW-1:0]     wr_addr;
    logic [7:0]        wr_data;
    seq_state_e        state_w;
    logic              show_status;
    logic [7:0]        status_w;
    logic              prog_go, erase_go;
    logic [MEM_AW-1:0] prog_addr;
    logic [7:0]        prog_data;
    logic [NSECT-1:0]  erase_mask;
    logic [7:0]        rdata;

    flash_bus_capture #(.AW(AW)) u_cap (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_active(wr_active), .rd_active(rd_active),
        .wr_done(wr_done), .rd_end(rd_end), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flash_seq_ctrl #(
        .AW(AW), .MEM_AW(MEM_AW), .SECT_AW(SECT_AW),
        .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .SE_WIN(SE_WIN)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_active(wr_active), .wr_done(wr_done),
        .rd_end(rd_end), .wr_addr(wr_addr), .wr_data(wr_data), .state(state_w),
        .show_status(show_status), .status(status_w), .prog_go(prog_go),
        .prog_addr(prog_addr), .prog_data(prog_data), .erase_go(erase_go),
        .erase_mask(erase_mask)
    );

    flash_cell_array #(.MEM_AW(MEM_AW), .SECT_AW(SECT_AW)) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_go(erase_go), .erase_mask(erase_mask),
        .raddr(addr[MEM_AW-1:0]), .rdata(rdata)
    );

    always_comb begin
        dout = 8'h00;
        if (rd_active) dout = show_status ? status_w : rdata;
    end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
    import flash_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_active,
    input logic       wr_done,
    input logic       rd_end,
    input logic [7:0] dout,
    input seq_state_e state,
    input logic       show_status,
    input logic [7:0] status,
    input logic       prog_go,
    input logic       erase_go,
    input logic       erase_any,
    input logic [7:0] prog_data
);
    assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |-> dout == 8'h00);

    assert_busy_deaf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM_BUSY && wr_done) |=> (state == ST_PGM_BUSY || state == ST_READ));

    assert_poll_bit7_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM_BUSY && rd_active) |-> dout[7] == ~prog_data[7]);

    assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (show_status && rd_end) |=> status[6] != $past(status[6]));

    assert_erase_poll_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ERS_BUSY || state == ST_SECT_WIN) && rd_active) |-> dout[7] == 1'b0);

    assert_single_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_go && erase_go));

    assert_erase_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> erase_any);

    assert_back_to_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> state == ST_READ);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_active(rd_active), .wr_done(wr_done),
    .rd_end(rd_end), .dout(dout), .state(state_w), .show_status(show_status),
    .status(status_w), .prog_go(prog_go), .erase_go(erase_go),
    .erase_any(|erase_mask), .prog_data(prog_data)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int AW = 11, MEM_AW = 6, SECT_AW = 2;
    localparam int PGM_CYC = 40, ERS_CYC = 60, SE_WIN = 24;
    localparam int DEPTH = 1 << MEM_AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;

    int checks = 0, errors = 0;
    logic [7:0] exp_mem [DEPTH];
    logic exp_tog = 1'b0;
    logic done = 1'b0;

    flash_cmd_seq #(.AW(AW), .MEM_AW(MEM_AW), .SECT_AW(SECT_AW),
        .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .SE_WIN(SE_WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout));

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%02h exp=%02h t=%0t", req, got, exp, $time);
        end
    endtask

    // per-clock reference: no read strobe means a silent data bus (R2)
    always @(posedge clk) begin
        #1;
        if (rst_n && !done && !(!ce_n && !oe_n && we_n)) chk("R2", dout, 8'h00);
    end

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk); addr = AW'(a); din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic do_read(input int a, output logic [7:0] v);
        @(negedge clk); addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); v = dout; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic read_chk(input string req, input int a);
        logic [7:0] v;
        do_read(a, v);
        chk(req, v, exp_mem[a]);
    endtask

    task automatic status_chk(input string req, input logic bit7);
        logic [7:0] v;
        do_read(0, v);
        chk(req, v, {bit7, exp_tog, 6'b0});
        exp_tog = ~exp_tog;
    endtask

    task automatic unlock_pgm();
        do_write('h555, 8'hAA); do_write('h2AA, 8'h55); do_write('h555, 8'hA0);
    endtask

    task automatic unlock_erase();
        do_write('h555, 8'hAA); do_write('h2AA, 8'h55); do_write('h555, 8'h80);
        do_write('h555, 8'hAA); do_write('h2AA, 8'h55);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic program_byte(input string req, input int a, input logic [7:0] d);
        unlock_pgm();
        do_write(a, d);
        status_chk("R6", ~d[7]);
        wait_cyc(PGM_CYC + 2);
        exp_mem[a] = exp_mem[a] & d;
        read_chk(req, a);
    endtask

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset contents
        read_chk("R1", 0); read_chk("R1", 33); read_chk("R1", 63);

        // R4 / R6: program, two status reads show bit 6 flipping
        unlock_pgm();
        do_write(5, 8'hA5);
        status_chk("R6", 1'b0);
        status_chk("R6", 1'b0);
        wait_cyc(PGM_CYC + 2);
        exp_mem[5] = 8'hA5;
        read_chk("R4", 5);

        // R5: bits only clear
        program_byte("R5", 5, 8'h5A);

        // R3: address from first both-low cycle, data from last
        unlock_pgm();
        @(negedge clk); addr = AW'(50); ce_n = 1'b0;
        @(negedge clk); addr = AW'(12); din = 8'hFF; we_n = 1'b0;
        @(negedge clk); addr = AW'(20); din = 8'h3C;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        wait_cyc(PGM_CYC + 2);
        exp_mem[12] = 8'h3C;
        read_chk("R3", 12); read_chk("R3", 20); read_chk("R3", 50);

        // R4: other sectors, any order
        program_byte("R4", 63, 8'h77);
        program_byte("R4", 20, 8'h11);
        program_byte("R4", 40, 8'h42);

        // R7: a full sequence during a busy program is ignored
        unlock_pgm();
        do_write(10, 8'h00);
        unlock_pgm();
        do_write(11, 8'h00);
        wait_cyc(PGM_CYC + 2);
        exp_mem[10] = 8'h00;
        read_chk("R7", 10); read_chk("R7", 11);

        // R11: broken sequence and F0h abort leave the array alone
        do_write('h555, 8'hAA); do_write('h2AA, 8'h12);
        do_write('h2AA, 8'h55); do_write('h555, 8'hA0); do_write(30, 8'h00);
        wait_cyc(PGM_CYC + 2);
        read_chk("R11", 30);
        do_write('h555, 8'hAA); do_write('h2AA, 8'h55); do_write('h555, 8'hF0);
        read_chk("R11", 5);
        do_write(31, 8'h00);
        wait_cyc(PGM_CYC + 2);
        read_chk("R11", 31);

        // R9: sector 0 then sector 2 inside the window
        unlock_erase();
        do_write(5, 8'h30);
        status_chk("R9", 1'b0);
        do_write(40, 8'h30);
        wait_cyc(SE_WIN + ERS_CYC + 4);
        for (int i = 0; i < 16; i++) begin exp_mem[i] = 8'hFF; exp_mem[32+i] = 8'hFF; end
        read_chk("R9", 5); read_chk("R9", 12); read_chk("R9", 10);
        read_chk("R9", 40); read_chk("R9", 20); read_chk("R9", 63);

        // R10: a non-30h write closes the window with no erase
        unlock_erase();
        do_write(20, 8'h30);
        do_write(20, 8'h55);
        read_chk("R10", 20);
        wait_cyc(SE_WIN + ERS_CYC + 4);
        read_chk("R10", 20);

        // R9 / R7: after the window expires a late 30h is ignored
        unlock_erase();
        do_write(63, 8'h30);
        wait_cyc(SE_WIN + 4);
        do_write(20, 8'h30);
        wait_cyc(ERS_CYC + 4);
        for (int i = 48; i < 64; i++) exp_mem[i] = 8'hFF;
        read_chk("R9", 63); read_chk("R7", 20);

        // R8: chip erase
        unlock_erase();
        do_write('h555, 8'h10);
        status_chk("R8", 1'b0);
        wait_cyc(ERS_CYC + 2);
        for (int i = 0; i < DEPTH; i++) begin
            exp_mem[i] = 8'hFF;
            read_chk("R8", i);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule